// File: doc/BRIEF.md
# Local countdown timer with vector table

This block is the countdown timer of one processor's local interrupt unit. Software loads an initial count. The count then falls by one each time a programmable number of bus-clock enables has gone by. When it reaches zero, the timer asks the interrupt resolver to take the timer vector. In periodic mode the count then starts again from the initial value. In one-shot mode it stays at zero.

The timer shares a six-entry local vector table with other interrupt sources. Every table write is filtered by a per-entry field mask. A software-enable bit in the spurious register can force every entry into the masked state. Writing an illegal low fixed-mode vector into a table entry records an error and raises the error entry's vector. The error-status register follows a two-write protocol.

Expiries that come while the timer request is still waiting are not lost. They are counted, and each one is replayed after the resolver reports an injection. Software reaches all registers through a single-cycle, 32-bit, word-indexed write and read port.

Top module: `loc_timer`

## Requirements
- R1: After reset the register indices read as follows: index 0 (initial count) reads 0, index 1 (current count) reads 0, index 2 (divide) reads 0, index 3 (spurious) reads 0xFF, index 4 (error status) reads 0, and every table entry reads 0x10000. After reset both request outputs are low.
- R2: The divide register is at index 2 and keeps only bits 3, 1 and 0. Let code = {bit3, bit1, bit0}. The count falls by one once every 2^(code+1) cycles in which tick_i is high, so code 0 gives a divisor of 2 and code 7 gives 256.
- R3: A write to index 0 stores the initial count, loads the current count with the same value and restarts the divider. Index 1 reads the live current count. Writes to index 1 are ignored. A count of zero stays at zero and never expires.
- R4: Table entry k sits at index 5+k, and entry 0 is the timer entry. When the count steps from 1, it reloads from the initial count if bit 17 of the timer entry is 1 (periodic). If that bit is 0 (one-shot), the count becomes 0 and stays there.
- R5: An expiry raises timer_irq_o, with timer_vec_o equal to bits 7:0 of the timer entry, only when bit 16 (mask) of the timer entry is 0. A masked expiry raises nothing.
- R6: An expiry that comes while timer_irq_o is already high adds one to a saturating backlog. A pulse on inj_timer_i with a nonzero backlog keeps timer_irq_o high and takes one from the backlog. With a zero backlog it clears timer_irq_o. When an injection and an expiry fall in the same cycle, timer_irq_o stays high and the backlog is unchanged. An injection while timer_irq_o is low has no effect.
- R7: A write to entry k stores the write data ANDed with a mask. Entry 0 uses 0x310FF, entries 1, 2 and 5 use 0x117FF, and entries 3 and 4 use 0x1F7FF.
- R8: A write to index 3 keeps bits 8:0. If bit 8 of the written value is 0, bit 16 is set in all six entries. While bit 8 of the stored value is 0, every later table write also stores with bit 16 set.
- R9: A table write whose stored bits 10:8 are 0 (fixed mode) and whose bits 7:0 are below 16 sets error-status bit 6. If software is enabled (spurious bit 8 is 1), the same write also raises err_irq_o, with err_vec_o equal to bits 7:0 of entry 5. A pulse on inj_err_i clears err_irq_o. A write in any other delivery mode raises nothing.
- R10: Each write to index 4 toggles a phase flag, and the status is cleared on every second write. Index 4 reads the status only while the phase flag is 1, so it reads 0 until the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Bus-clock enable that feeds the divider |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| inj_timer_i | input | 1 | Resolver has injected the timer vector |
| inj_err_i | input | 1 | Resolver has injected the error vector |
| timer_irq_o | output | 1 | Timer vector request |
| timer_vec_o | output | 8 | Timer vector |
| err_irq_o | output | 1 | Error vector request |
| err_vec_o | output | 8 | Error vector |

## Verification
The hard case is an injection from the resolver that lands in the same cycle as a new expiry. The backlog logic must retire the old request and enter the new one at the same time. The bench provokes this by watching its own model for the cycle in which the divider step will take the count from one to zero, with a request waiting and no backlog, and pulsing the injection exactly then. It judges the result by the request staying high, and by the later drain of the backlog needing exactly the number of injections the model predicts, which is checked every clock.

// File: rtl/loc_timer_pkg.sv
package loc_timer_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned ADDR_W     = 4;
  localparam int unsigned NUM_LVT    = 6;
  localparam int unsigned DIV_CODE_W = 3;
  localparam int unsigned PRE_W      = 1 << DIV_CODE_W;
  localparam int unsigned SPUR_W     = 9;
  localparam int unsigned ESR_W      = 8;

  localparam logic [ADDR_W-1:0] A_INIT = 4'd0;
  localparam logic [ADDR_W-1:0] A_CUR  = 4'd1;
  localparam logic [ADDR_W-1:0] A_DIV  = 4'd2;
  localparam logic [ADDR_W-1:0] A_SPUR = 4'd3;
  localparam logic [ADDR_W-1:0] A_ESR  = 4'd4;
  localparam logic [ADDR_W-1:0] A_LVT0 = 4'd5;

  localparam int unsigned LVT_TIMER    = 0;
  localparam int unsigned LVT_ERROR    = 5;
  localparam int unsigned MASK_BIT     = 16;
  localparam int unsigned PERIODIC_BIT = 17;
  localparam int unsigned SW_EN_BIT    = 8;
  localparam int unsigned BADVEC_BIT   = 6;

  function automatic logic [DATA_W-1:0] lvt_wmask(input int unsigned k);
    case (k)
      0:       lvt_wmask = 32'h0003_10FF;
      3, 4:    lvt_wmask = 32'h0001_F7FF;
      default: lvt_wmask = 32'h0001_17FF;
    endcase
  endfunction
endpackage

// File: rtl/loc_timer_div.sv
module loc_timer_div
  import loc_timer_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic                  clr_i,
  input  logic [DIV_CODE_W-1:0] code_i,
  output logic                  step_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;
  logic [PRE_W:0]   full;

  assign full   = (PRE_W+1)'(1) << ({1'b0, code_i} + (DIV_CODE_W+1)'(1));
  assign lim    = PRE_W'(full - (PRE_W+1)'(1));
  // >= keeps a shrunken divisor from wrapping the prescaler
  assign step_o = tick_i && (pre_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (tick_i) pre_q <= step_o ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/loc_timer_cnt.sv
module loc_timer_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] init_i,
  input  logic             periodic_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cur_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cur_q;

  assign cur_o    = cur_q;
  assign expire_o = step_i && !load_i && (cur_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '0;
    else if (load_i) cur_q <= load_val_i;
    else if (step_i && cur_q != '0) begin
      if (cur_q == CNT_W'(1)) cur_q <= periodic_i ? init_i : '0;
      else                    cur_q <= cur_q - 1'b1;
    end
  end
endmodule

// File: rtl/loc_timer_pend.sv
module loc_timer_pend #(
  parameter int unsigned PEND_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              inject_i,
  output logic              req_o,
  output logic [PEND_W-1:0] backlog_o
);
  logic              req_q, req_mid, req_d;
  logic [PEND_W-1:0] back_q, back_mid, back_d;

  always_comb begin
    req_mid  = req_q;
    back_mid = back_q;
    if (inject_i) begin
      req_mid = (back_q != '0);
      if (back_q != '0) back_mid = back_q - 1'b1;
    end
    req_d  = req_mid;
    back_d = back_mid;
    if (fire_i) begin
      if (!req_mid)             req_d  = 1'b1;
      else if (back_mid != '1)  back_d = back_mid + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      back_q <= '0;
    end else begin
      req_q  <= req_d;
      back_q <= back_d;
    end
  end

  assign req_o     = req_q;
  assign backlog_o = back_q;
endmodule

// File: rtl/loc_timer.sv
module loc_timer
  import loc_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PEND_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              inj_timer_i,
  input  logic              inj_err_i,
  output logic              timer_irq_o,
  output logic [7:0]        timer_vec_o,
  output logic              err_irq_o,
  output logic [7:0]        err_vec_o
);
  localparam logic [DATA_W-1:0] MASK_ONE = DATA_W'(1) << MASK_BIT;

  logic [CNT_W-1:0]  init_q, cur;
  logic [3:0]        div_q;
  logic [SPUR_W-1:0] spur_q;
  logic [ESR_W-1:0]  esr_q;
  logic              esr_phase_q;
  logic              err_req_q;
  logic [DATA_W-1:0] lvt_q   [NUM_LVT];
  logic [DATA_W-1:0] lvt_new [NUM_LVT];
  logic [NUM_LVT-1:0] lvt_sel, lvt_bad, lvt_masked;
  logic              sw_en, init_wr, div_wr, spur_wr, esr_wr, lvt_bad_any;
  logic              step, expire, timer_fire;
  logic [PEND_W-1:0] backlog;

  assign sw_en   = spur_q[SW_EN_BIT];
  assign init_wr = reg_we_i && reg_addr_i == A_INIT;
  assign div_wr  = reg_we_i && reg_addr_i == A_DIV;
  assign spur_wr = reg_we_i && reg_addr_i == A_SPUR;
  assign esr_wr  = reg_we_i && reg_addr_i == A_ESR;

  for (genvar k = 0; k < NUM_LVT; k++) begin : g_lvt
    assign lvt_sel[k] = reg_we_i && (reg_addr_i == A_LVT0 + ADDR_W'(k));
    assign lvt_new[k] = (reg_wdata_i & lvt_wmask(k)) | (sw_en ? '0 : MASK_ONE);
    assign lvt_bad[k] = lvt_sel[k] && (lvt_new[k][10:8] == 3'd0) && (lvt_new[k][7:0] < 8'd16);
    assign lvt_masked[k] = lvt_q[k][MASK_BIT];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  lvt_q[k] <= MASK_ONE;
      else if (lvt_sel[k])                          lvt_q[k] <= lvt_new[k];
      else if (spur_wr && !reg_wdata_i[SW_EN_BIT])  lvt_q[k] <= lvt_q[k] | MASK_ONE;
    end
  end

  assign lvt_bad_any = |lvt_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= '0;
      div_q  <= '0;
      spur_q <= SPUR_W'(9'h0FF);
    end else begin
      if (init_wr) init_q <= reg_wdata_i[CNT_W-1:0];
      if (div_wr)  div_q  <= reg_wdata_i[3:0] & 4'hB;
      if (spur_wr) spur_q <= reg_wdata_i[SPUR_W-1:0];
    end
  end

  // error status: write toggles phase, second write clears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      esr_q       <= '0;
      esr_phase_q <= 1'b0;
    end else if (esr_wr) begin
      esr_phase_q <= ~esr_phase_q;
      if (esr_phase_q) esr_q <= '0;
    end else if (lvt_bad_any) begin
      esr_q[BADVEC_BIT] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   err_req_q <= 1'b0;
    else if (lvt_bad_any && sw_en) err_req_q <= 1'b1;
    else if (inj_err_i)            err_req_q <= 1'b0;
  end

  loc_timer_div i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (init_wr),
    .code_i ({div_q[3], div_q[1:0]}),
    .step_o (step)
  );

  loc_timer_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (init_wr),
    .load_val_i (reg_wdata_i[CNT_W-1:0]),
    .init_i     (init_q),
    .periodic_i (lvt_q[LVT_TIMER][PERIODIC_BIT]),
    .step_i     (step),
    .cur_o      (cur),
    .expire_o   (expire)
  );

  assign timer_fire = expire && !lvt_q[LVT_TIMER][MASK_BIT];

  loc_timer_pend #(.PEND_W(PEND_W)) i_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (timer_fire),
    .inject_i  (inj_timer_i),
    .req_o     (timer_irq_o),
    .backlog_o (backlog)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_INIT:  reg_rdata_o = DATA_W'(init_q);
      A_CUR:   reg_rdata_o = DATA_W'(cur);
      A_DIV:   reg_rdata_o = DATA_W'(div_q);
      A_SPUR:  reg_rdata_o = DATA_W'(spur_q);
      A_ESR:   reg_rdata_o = esr_phase_q ? DATA_W'(esr_q) : '0;
      default: begin
        for (int k = 0; k < NUM_LVT; k++)
          if (reg_addr_i == A_LVT0 + ADDR_W'(k)) reg_rdata_o = lvt_q[k];
      end
    endcase
  end

  assign timer_vec_o = lvt_q[LVT_TIMER][7:0];
  assign err_irq_o   = err_req_q;
  assign err_vec_o   = lvt_q[LVT_ERROR][7:0];
endmodule

// File: rtl/loc_timer_chk.sv
module loc_timer_chk #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PEND_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sw_en,
  input logic [5:0]        lvt_masked,
  input logic              expire,
  input logic              load,
  input logic              periodic,
  input logic [CNT_W-1:0]  cur,
  input logic [CNT_W-1:0]  init,
  input logic              inject,
  input logic [PEND_W-1:0] backlog,
  input logic              treq
);
  // R8
  sw_off_masks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_en |-> (&lvt_masked));
  // R4
  oneshot_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !load && !periodic) |=> (cur == '0));
  // R4
  periodic_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !load && periodic) |=> (cur == $past(init)));
  // R6
  backlog_has_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (backlog != '0) |-> treq);
  // R6
  inject_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inject && backlog == '0 && !expire) |=> !treq);
  // R3
  zero_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init == '0 && !load) |=> (cur == '0));
endmodule

bind loc_timer loc_timer_chk #(.CNT_W(CNT_W), .PEND_W(PEND_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sw_en      (sw_en),
  .lvt_masked (lvt_masked),
  .expire     (expire),
  .load       (init_wr),
  .periodic   (lvt_q[0][17]),
  .cur        (cur),
  .init       (init_q),
  .inject     (inj_timer_i),
  .backlog    (backlog),
  .treq       (timer_irq_o)
);

// File: tb/test_loc_timer.sv
`timescale 1ns/100ps
module test_loc_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        we = 1'b0;
  logic [3:0]  addr = 4'd1;
  logic [31:0] wdata = '0;
  logic        inj_t = 1'b0, inj_e = 1'b0;
  logic [31:0] rdata;
  logic        timer_irq, err_irq;
  logic [7:0]  timer_vec, err_vec;

  int n_chk = 0, n_fail = 0;
  bit gate_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  loc_timer i_loc_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .inj_timer_i(inj_t), .inj_err_i(inj_e),
    .timer_irq_o(timer_irq), .timer_vec_o(timer_vec), .err_irq_o(err_irq), .err_vec_o(err_vec)
  );

  // reference model
  int unsigned m_init = 0, m_cur = 0;
  int          m_pre = 0, m_back = 0;
  bit [3:0]    m_div = 0;
  bit [8:0]    m_spur = 9'h0FF;
  bit [31:0]   m_lvt [6] = '{default: 32'h10000};
  bit [7:0]    m_esr = 0;
  bit          m_ph = 0, m_treq = 0, m_ereq = 0;

  function automatic bit [31:0] wmask(int k);
    if (k == 0) return 32'h310FF;
    if (k == 3 || k == 4) return 32'h1F7FF;
    return 32'h117FF;
  endfunction

  function automatic int lim_of(bit [3:0] d);
    return (1 << ({d[3], d[1:0]} + 1)) - 1;
  endfunction

  function automatic bit [31:0] m_read(logic [3:0] a);
    case (a)
      0: return m_init;
      1: return m_cur;
      2: return {28'd0, m_div};
      3: return {23'd0, m_spur};
      4: return m_ph ? {24'd0, m_esr} : 32'd0;
      default: return (a >= 5 && a <= 10) ? m_lvt[a-5] : 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] a);
    case (a)
      0, 1: return "R3";
      2: return "R2";
      3: return "R8";
      4: return "R10";
      default: return "R7";
    endcase
  endfunction

  always @(posedge clk) begin
    bit step, load, expire, fire, rq, bad;
    int bk;
    bit [31:0] nv;
    if (!rst_n) begin
      m_init = 0; m_cur = 0; m_pre = 0; m_back = 0; m_div = 0; m_spur = 9'h0FF;
      foreach (m_lvt[k]) m_lvt[k] = 32'h10000;
      m_esr = 0; m_ph = 0; m_treq = 0; m_ereq = 0;
    end else begin
      load   = we && addr == 0;
      step   = tick && m_pre >= lim_of(m_div);
      expire = step && !load && m_cur == 1;
      fire   = expire && !m_lvt[0][16];
      rq = m_treq; bk = m_back;
      if (inj_t) begin rq = (bk > 0); if (bk > 0) bk--; end
      if (fire) begin if (!rq) rq = 1; else if (bk < 15) bk++; end
      m_treq = rq; m_back = bk;
      if (load) m_pre = 0; else if (tick) m_pre = step ? 0 : m_pre + 1;
      if (load) m_cur = wdata;
      else if (step && m_cur != 0) m_cur = (m_cur == 1) ? (m_lvt[0][17] ? m_init : 0) : m_cur - 1;
      bad = 0;
      if (inj_e) m_ereq = 0;
      if (we) begin
        case (addr)
          0: m_init = wdata;
          2: m_div = wdata[3:0] & 4'hB;
          3: begin
            m_spur = wdata[8:0];
            if (!wdata[8]) foreach (m_lvt[k]) m_lvt[k][16] = 1;
          end
          4: begin if (m_ph) m_esr = 0; m_ph = !m_ph; end
          default: if (addr >= 5 && addr <= 10) begin
            nv = wdata & wmask(addr - 5);
            if (!m_spur[8]) nv[16] = 1;
            if (nv[10:8] == 0 && nv[7:0] < 16) bad = 1;
            if (bad && m_spur[8]) m_ereq = 1;
            m_lvt[addr-5] = nv;
          end
        endcase
      end
      if (bad) m_esr[6] = 1;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    check("R5", {31'd0, timer_irq}, {31'd0, m_treq});
    check("R9", {31'd0, err_irq}, {31'd0, m_ereq});
    check("R7", {24'd0, timer_vec}, {24'd0, m_lvt[0][7:0]});
    check("R7", {24'd0, err_vec}, {24'd0, m_lvt[5][7:0]});
    check(tag_of(addr), rdata, m_read(addr));
  end

  always @(negedge clk) begin
    #0.5;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tick = gate_en ? lfsr[0] : 1'b1;
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); #0.5; we = 1; addr = a; wdata = d;
    @(negedge clk); #0.5; we = 0; addr = 4'd1;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
    @(negedge clk); #0.5; addr = a;
    @(negedge clk); check(tag, rdata, exp);
    #0.5; addr = 4'd1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_t(int n);
    repeat (n) begin
      @(negedge clk); #0.5; inj_t = 1;
      @(negedge clk); #0.5; inj_t = 0;
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    bit found;
    repeat (3) @(negedge clk);
    #0.5 rst_n = 1;
    // R1 reset state
    rd(3, 32'h0FF, "R1");
    rd(5, 32'h10000, "R1");
    rd(10, 32'h10000, "R1");
    rd(1, 32'h0, "R1");
    rd(4, 32'h0, "R1");
    check("R1", {31'd0, timer_irq}, 32'd0);
    // R8 keeps 9 bits, enable
    wr(3, 32'h3FF);
    rd(3, 32'h1FF, "R8");
    // R7 per-entry masks
    wr(5, 32'hFFFF_FFFF); rd(5, 32'h310FF, "R7");
    wr(6, 32'hFFFF_FFFF); rd(6, 32'h117FF, "R7");
    wr(8, 32'hFFFF_FFFF); rd(8, 32'h1F7FF, "R7");
    wr(10, 32'h33);       rd(10, 32'h33, "R7");
    // R2 divide keeps bits 3,1,0
    wr(2, 32'hF); rd(2, 32'hB, "R2");
    // R4/R5 periodic, divisor 2
    wr(2, 32'h0);
    wr(5, 32'h20040);
    wr(0, 32'd3);
    rd(0, 32'd3, "R3");
    idle(10);
    check("R5", {31'd0, timer_irq}, 32'd1);
    check("R5", {24'd0, timer_vec}, 32'h40);
    // R6 backlog builds up
    idle(30);
    pulse_t(1);
    check("R6", {31'd0, timer_irq}, 32'd1);
    // R3 init zero holds
    wr(0, 32'd0);
    idle(20);
    rd(1, 32'd0, "R3");
    pulse_t(20);
    check("R6", {31'd0, timer_irq}, 32'd0);
    pulse_t(1);
    check("R6", {31'd0, timer_irq}, 32'd0);
    // R6 injection coinciding with expiry
    wr(0, 32'd3);
    idle(8);
    found = 0;
    for (int i = 0; i < 200 && !found; i++) begin
      @(negedge clk); #0.5;
      if (m_pre >= lim_of(m_div) && m_cur == 1 && m_treq && m_back == 0) begin
        inj_t = 1; found = 1;
        @(negedge clk);
        check("R6", {31'd0, timer_irq}, 32'd1);
        #0.5 inj_t = 0;
      end else if (m_treq && m_back > 0) begin
        inj_t = 1;
        @(negedge clk); #0.5 inj_t = 0;
      end
    end
    check("R6", {31'd0, found}, 32'd1);
    wr(0, 32'd0);
    pulse_t(20);
    // R5 masked expiry raises nothing
    wr(5, 32'h10040);
    wr(0, 32'd2);
    idle(20);
    check("R5", {31'd0, timer_irq}, 32'd0);
    // R4 one-shot, divisor 32 (code 4)
    wr(2, 32'h8);
    wr(5, 32'h00041);
    wr(0, 32'd2);
    idle(40);
    rd(1, 32'd1, "R2");
    check("R4", {31'd0, timer_irq}, 32'd0);
    idle(40);
    check("R4", {31'd0, timer_irq}, 32'd1);
    idle(100);
    rd(1, 32'd0, "R4");
    pulse_t(1);
    check("R4", {31'd0, timer_irq}, 32'd0);
    // R2 divisor 256 (code 7)
    wr(2, 32'hB);
    wr(0, 32'd1);
    idle(200);
    check("R2", {31'd0, timer_irq}, 32'd0);
    idle(100);
    check("R2", {31'd0, timer_irq}, 32'd1);
    pulse_t(1);
    // gated ticks, periodic
    wr(2, 32'h1);
    wr(5, 32'h20050);
    gate_en = 1;
    wr(0, 32'd5);
    for (int i = 0; i < 40; i++) begin idle(7); if (i % 3 == 0) pulse_t(1); end
    gate_en = 0;
    wr(0, 32'd0);
    pulse_t(20);
    // R3 current-count write ignored
    wr(1, 32'h1234);
    rd(1, 32'd0, "R3");
    // R8 software disable
    wr(3, 32'h0FF);
    rd(5, 32'h30050, "R8");
    wr(7, 32'h0);
    rd(7, 32'h10000, "R8");
    check("R9", {31'd0, err_irq}, 32'd0);
    // R10 error status phases
    wr(4, 32'h0); rd(4, 32'h40, "R10");
    wr(4, 32'h0); rd(4, 32'h0, "R10");
    wr(4, 32'h0); rd(4, 32'h0, "R10");
    // R9 illegal vector with software enabled
    wr(3, 32'h100);
    wr(9, 32'h5);
    check("R9", {31'd0, err_irq}, 32'd1);
    check("R9", {24'd0, err_vec}, 32'h33);
    rd(4, 32'h40, "R9");
    @(negedge clk); #0.5 inj_e = 1;
    @(negedge clk); #0.5 inj_e = 0;
    check("R9", {31'd0, err_irq}, 32'd0);
    wr(9, 32'h405);
    check("R9", {31'd0, err_irq}, 32'd0);
    idle(5);
    finish_up();
  end
endmodule